// File: doc/BRIEF.md
# Paced Serial Receive Queue

This block sits between a serial receiver and the software or logic that consumes received characters. Every character the receiver delivers is written into a 256-entry circular store, tracked by a fill count, a read pointer and a write pointer. The consumer pops characters one at a time, and an empty indication tells it when nothing is waiting. A full flag shows that no further character can be stored. A character that arrives while the store is full is lost and leaves a sticky overflow flag.

The block also paces both directions of the link in hardware. When the store is nearly full and local receive pacing is on, it queues an XOFF (0x13) for the transmitter. Once the store has drained far enough, it queues an XON (0x11). These flow-control characters wait in a one-deep request register until the transmitter is free, and they always go ahead of user traffic. In the other direction, XOFF and XON characters from the remote end are picked out at the receive side. They set and clear a pause flag that holds back user transmission, so the consumer never has to search the stored data for them.

Top module: `rxq_pacer`

## Requirements
- R1: Stored characters come out in arrival order. While `pop_empty` is low, `pop_data` shows the oldest stored character, and `pop_req` removes it at the next clock edge. Up to 256 characters can be held.
- R2: `pop_empty` is high exactly when nothing is stored. A `pop_req` while empty changes nothing.
- R3: `full` is high exactly when 256 characters are stored. A character that arrives while `full` is high is dropped and sets `overflow`, which stays set until reset.
- R4: When a character is stored, `rx_pace_en` is high, `xoff_sent` is low, and fewer than 16 free entries remain afterwards, `xoff_sent` is set and an XOFF (0x13) request becomes pending.
- R5: A pending flow-control request (`fc_pending`) is held while `tx_busy` is high. It is sent on `tx_data` in the first cycle that `tx_busy` is low, and it is cleared at that edge. A newer request replaces an unsent one.
- R6: While `xoff_sent` is high and 64 or more entries are free after the current cycle's update, an XON (0x11) request becomes pending and `xoff_sent` is cleared.
- R7: With `tx_pace_en` high, a received 0x13 sets `paused` and a received 0x11 clears it, and neither character is stored. With `tx_pace_en` low, both are stored as ordinary data and `paused` does not change.
- R8: `usr_ready` is high exactly when `tx_busy` is low, no flow-control request is pending, and `paused` is not in force with `tx_pace_en` high. The user character is passed to `tx_data` with `tx_valid` when `usr_valid` and `usr_ready` are both high.
- R9: When a flow-control character and a user character compete for the transmitter in the same cycle, the flow-control character is sent and the user character is refused. `tx_valid` is never high while `tx_busy` is high.
- R10: After reset the store is empty, and `full`, `overflow`, `paused`, `xoff_sent`, `fc_pending` and `tx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| pop_req | input | 1 | Remove the oldest stored character |
| pop_data | output | 8 | Oldest stored character |
| pop_empty | output | 1 | Nothing stored |
| full | output | 1 | No room for another character |
| overflow | output | 1 | Sticky: a character was dropped because the store was full |
| rx_pace_en | input | 1 | Enable local XOFF/XON generation |
| tx_pace_en | input | 1 | Honour XOFF/XON from the remote end |
| usr_valid | input | 1 | User character offered for transmission |
| usr_data | input | 8 | User character |
| usr_ready | output | 1 | User character is accepted this cycle |
| tx_busy | input | 1 | Transmitter cannot take a character |
| tx_valid | output | 1 | Character handed to the transmitter |
| tx_data | output | 8 | Character to transmit |
| paused | output | 1 | Remote end has requested a pause |
| xoff_sent | output | 1 | XOFF issued and not yet followed by XON |
| fc_pending | output | 1 | Flow-control character waiting for the transmitter |

## Verification
Directed runs fill the store with the transmitter idle and then with it busy. The idle case checks the XOFF going out straight away, and the busy case checks that it is held as a pending request. The store is then filled past capacity to reach the overflow and full boundaries, and drained to the XON threshold. Remote XOFF and XON are sent with remote pacing both on and off, which shows consumption and pausing against plain storage. Random phases then alternate between fill-heavy and drain-heavy traffic with a random busy transmitter and scattered control characters. This crosses both thresholds many times, including cases where a new request replaces an unsent one.

// File: rtl/rxq_pkg.sv
// Shared types for the paced receive queue.
// Assumes 8-bit characters throughout.
package rxq_pkg;
    typedef logic [7:0] byte_t;

    // Kind of flow-control character waiting for the transmitter
    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_STOP = 2'd1,
        FC_GO   = 2'd2
    } fc_kind_e;
endpackage

// File: rtl/rxq_ring.sv
// Circular character store with fill count, read and write pointers.
// Keeps a sticky overflow flag for characters dropped while full.
// Assumes DEPTH is a power of two so the pointers wrap by truncation.
// The output shows the count as it will be after this cycle's update.
module rxq_ring #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  rxq_pkg::byte_t wr_data,
    input  logic          rd_en,
    output rxq_pkg::byte_t rd_data,
    output logic [CW-1:0] count_nx,
    output logic          empty,
    output logic          full,
    output logic          stored,
    output logic          overflow
);
    rxq_pkg::byte_t mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    logic [CW-1:0]  count;
    logic           pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign stored  = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Next fill count after this cycle's store and removal
    always_comb begin
        count_nx = count;
        if (stored && !pop)
            count_nx = count + CW'(1);
        else if (pop && !stored)
            count_nx = count - CW'(1);
    end

    // Character storage, written only on accepted arrivals
    always_ff @(posedge clk) begin
        if (stored)
            mem[wr_ptr] <= wr_data;
    end

    // Pointer, count and overflow state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            count <= count_nx;
            if (stored)
                wr_ptr <= wr_ptr + AW'(1);
            if (pop)
                rd_ptr <= rd_ptr + AW'(1);
            if (wr_en && full)
                overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_rx_filter.sv
// Classifies arriving characters. With remote pacing honoured, stop and go
// characters are taken out of the data stream and drive the pause flag.
// Everything else is passed on for storage.
module rxq_rx_filter #(
    parameter rxq_pkg::byte_t STOP_CH = 8'h13,
    parameter rxq_pkg::byte_t GO_CH   = 8'h11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_valid,
    input  rxq_pkg::byte_t rx_data,
    input  logic           honour_en,
    output logic           store_req,
    output logic           paused
);
    logic is_stop;
    logic is_go;
    logic ctrl_hit;

    assign is_stop   = (rx_data == STOP_CH);
    assign is_go     = (rx_data == GO_CH);
    assign ctrl_hit  = rx_valid && honour_en && (is_stop || is_go);
    assign store_req = rx_valid && !ctrl_hit;

    // Pause flag follows the last honoured control character
    always_ff @(posedge clk) begin
        if (!rst_n)
            paused <= 1'b0;
        else if (ctrl_hit)
            paused <= is_stop;
    end
endmodule

// File: rtl/rxq_fc_ctrl.sv
// Decides when to ask the remote end to stop or resume. The decision uses
// the free space left after this cycle's update. A single request register
// holds the latest character until the transmitter takes it.
module rxq_fc_ctrl #(
    parameter int DEPTH   = 256,
    parameter int CW      = $clog2(DEPTH + 1),
    parameter int HI_FREE = 16,
    parameter int LO_FREE = 64,
    parameter rxq_pkg::byte_t STOP_CH = 8'h13,
    parameter rxq_pkg::byte_t GO_CH   = 8'h11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stored,
    input  logic [CW-1:0]  count_nx,
    input  logic           pace_en,
    input  logic           fc_taken,
    output logic           fc_pending,
    output rxq_pkg::byte_t fc_char,
    output logic           xoff_sent
);
    rxq_pkg::fc_kind_e kind;
    logic [CW-1:0]     free_nx;
    logic              stop_due;
    logic              go_due;

    assign free_nx    = CW'(DEPTH) - count_nx;
    assign stop_due   = stored && pace_en && !xoff_sent && (free_nx < CW'(HI_FREE));
    assign go_due     = xoff_sent && (free_nx >= CW'(LO_FREE));
    assign fc_pending = (kind != rxq_pkg::FC_NONE);
    assign fc_char    = (kind == rxq_pkg::FC_GO) ? GO_CH : STOP_CH;

    // Request register; a new decision replaces any unsent one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind      <= rxq_pkg::FC_NONE;
            xoff_sent <= 1'b0;
        end else if (stop_due) begin
            kind      <= rxq_pkg::FC_STOP;
            xoff_sent <= 1'b1;
        end else if (go_due) begin
            kind      <= rxq_pkg::FC_GO;
            xoff_sent <= 1'b0;
        end else if (fc_taken) begin
            kind      <= rxq_pkg::FC_NONE;
        end
    end
endmodule

// File: rtl/rxq_tx_arb.sv
// Transmit arbiter. Flow-control characters win over user characters.
// User characters are held back while the remote end has paused.
// Purely combinational; the transmitter samples tx_valid and tx_data at the edge.
module rxq_tx_arb (
    input  logic           fc_pending,
    input  rxq_pkg::byte_t fc_char,
    input  logic           usr_valid,
    input  rxq_pkg::byte_t usr_data,
    input  logic           paused,
    input  logic           honour_en,
    input  logic           tx_busy,
    output logic           fc_taken,
    output logic           usr_ready,
    output logic           tx_valid,
    output rxq_pkg::byte_t tx_data
);
    // Grant the single transmit slot
    always_comb begin
        fc_taken  = fc_pending && !tx_busy;
        usr_ready = !tx_busy && !fc_pending && !(paused && honour_en);
        tx_valid  = fc_taken || (usr_ready && usr_valid);
        tx_data   = fc_taken ? fc_char : usr_data;
    end
endmodule

// File: rtl/rxq_pacer.sv
// Paced serial receive queue: a circular store for received characters,
// XOFF/XON generation from its fill level, remote pause detection and
// transmit arbitration. Assumes DEPTH is a power of two.
module rxq_pacer #(
    parameter int DEPTH   = 256,
    parameter int HI_FREE = 16,
    parameter int LO_FREE = 64,
    parameter logic [7:0] XOFF_CH = 8'h13,
    parameter logic [7:0] XON_CH  = 8'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       pop_req,
    output logic [7:0] pop_data,
    output logic       pop_empty,
    output logic       full,
    output logic       overflow,
    input  logic       rx_pace_en,
    input  logic       tx_pace_en,
    input  logic       usr_valid,
    input  logic [7:0] usr_data,
    output logic       usr_ready,
    input  logic       tx_busy,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       paused,
    output logic       xoff_sent,
    output logic       fc_pending
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic           store_req;
    logic           stored;
    logic [CW-1:0]  count_nx;
    logic           fc_taken;
    rxq_pkg::byte_t fc_char;

    rxq_rx_filter #(.STOP_CH(XOFF_CH), .GO_CH(XON_CH)) filt_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .honour_en(tx_pace_en), .store_req(store_req), .paused(paused)
    );

    rxq_ring #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ring_i (
        .clk(clk), .rst_n(rst_n), .wr_en(store_req), .wr_data(rx_data),
        .rd_en(pop_req), .rd_data(pop_data), .count_nx(count_nx),
        .empty(pop_empty), .full(full), .stored(stored), .overflow(overflow)
    );

    rxq_fc_ctrl #(
        .DEPTH(DEPTH), .CW(CW), .HI_FREE(HI_FREE), .LO_FREE(LO_FREE),
        .STOP_CH(XOFF_CH), .GO_CH(XON_CH)
    ) fc_i (
        .clk(clk), .rst_n(rst_n), .stored(stored), .count_nx(count_nx),
        .pace_en(rx_pace_en), .fc_taken(fc_taken), .fc_pending(fc_pending),
        .fc_char(fc_char), .xoff_sent(xoff_sent)
    );

    rxq_tx_arb arb_i (
        .fc_pending(fc_pending), .fc_char(fc_char), .usr_valid(usr_valid),
        .usr_data(usr_data), .paused(paused), .honour_en(tx_pace_en),
        .tx_busy(tx_busy), .fc_taken(fc_taken), .usr_ready(usr_ready),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );
endmodule

// File: rtl/rxq_pacer_chk.sv
// Port-level temporal checks for rxq_pacer, attached by bind.
module rxq_pacer_chk #(
    parameter logic [7:0] XOFF_CH = 8'h13,
    parameter logic [7:0] XON_CH  = 8'h11
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       pop_empty,
    input logic       full,
    input logic       overflow,
    input logic       tx_pace_en,
    input logic       usr_ready,
    input logic       tx_busy,
    input logic       tx_valid,
    input logic       paused,
    input logic       fc_pending
);
    logic ctrl_char;
    assign ctrl_char = tx_pace_en && ((rx_data == XOFF_CH) || (rx_data == XON_CH));

    AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pop_empty |-> !full); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid && !ctrl_char) |=> overflow); // R3
    AST_PAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && tx_pace_en && rx_data == XOFF_CH) |=> paused); // R7
    AST_PAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && tx_pace_en && rx_data == XON_CH) |=> !paused); // R7
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_pending && tx_busy) |=> fc_pending); // R5
    AST_PAUSE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && tx_pace_en) |-> !usr_ready); // R8
    AST_FC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_pending && !tx_busy) |-> (tx_valid && !usr_ready)); // R9
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_valid); // R9
endmodule

bind rxq_pacer rxq_pacer_chk #(.XOFF_CH(XOFF_CH), .XON_CH(XON_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .pop_empty(pop_empty), .full(full), .overflow(overflow),
    .tx_pace_en(tx_pace_en), .usr_ready(usr_ready), .tx_busy(tx_busy),
    .tx_valid(tx_valid), .paused(paused), .fc_pending(fc_pending)
);

// File: tb/rxq_pacer_tb_top.sv
module rxq_pacer_tb_top;
    localparam int CLK_P = 10;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, pop_req = 1'b0, usr_valid = 1'b0, tx_busy = 1'b0;
    logic [7:0] rx_data = '0, usr_data = '0;
    logic       rx_pace_en = 1'b0, tx_pace_en = 1'b0;
    logic [7:0] pop_data, tx_data;
    logic       pop_empty, full, overflow, usr_ready, tx_valid, paused, xoff_sent, fc_pending;

    bit hs_rx, hs_tx, done;

    rxq_pacer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_empty(pop_empty),
        .full(full), .overflow(overflow), .rx_pace_en(rx_pace_en),
        .tx_pace_en(tx_pace_en), .usr_valid(usr_valid), .usr_data(usr_data),
        .usr_ready(usr_ready), .tx_busy(tx_busy), .tx_valid(tx_valid),
        .tx_data(tx_data), .paused(paused), .xoff_sent(xoff_sent),
        .fc_pending(fc_pending)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;

    // Reference state
    byte unsigned mq[$];
    bit m_xs, m_pause, m_ovf, m_pend;
    byte unsigned m_fc;

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    function automatic bit is_ctl(byte unsigned d);
        return (d == 8'h13) || (d == 8'h11);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 0; pop_req = 0; usr_valid = 0; tx_busy = 0;
        repeat (3) @(negedge clk);
        mq.delete(); m_xs = 0; m_pause = 0; m_ovf = 0; m_pend = 0; m_fc = 0;
        // R10: state after reset
        chk(pop_empty == 1'b1, "R10", "pop_empty", pop_empty, 1);
        chk(full == 1'b0, "R10", "full", full, 0);
        chk(overflow == 1'b0, "R10", "overflow", overflow, 0);
        chk(paused == 1'b0, "R10", "paused", paused, 0);
        chk(xoff_sent == 1'b0, "R10", "xoff_sent", xoff_sent, 0);
        chk(fc_pending == 1'b0, "R10", "fc_pending", fc_pending, 0);
        chk(tx_valid == 1'b0, "R10", "tx_valid", tx_valid, 0);
        rst_n = 1'b1;
    endtask

    // One cycle: drive, compare against the reference, advance the reference
    task automatic step(bit rv, byte unsigned rd, bit pr, bit busy, bit uv, byte unsigned ud);
        bit exp_fc, exp_ur, exp_tv, ctrl, push, pop;
        int free;
        @(negedge clk);
        rx_valid = rv; rx_data = rd; pop_req = pr; tx_busy = busy;
        usr_valid = uv; usr_data = ud; rx_pace_en = hs_rx; tx_pace_en = hs_tx;
        #1;
        chk(pop_empty == (mq.size() == 0), "R2", "pop_empty", pop_empty, mq.size() == 0);
        chk(full == (mq.size() == DEPTH), "R3", "full", full, mq.size() == DEPTH);
        if (mq.size() > 0)
            chk(pop_data == mq[0], "R1", "pop_data", pop_data, mq[0]);
        chk(overflow == m_ovf, "R3", "overflow", overflow, m_ovf);
        chk(paused == m_pause, "R7", "paused", paused, m_pause);
        chk(xoff_sent == m_xs, "R4 R6", "xoff_sent", xoff_sent, m_xs);
        chk(fc_pending == m_pend, "R5", "fc_pending", fc_pending, m_pend);
        exp_fc = m_pend && !busy;
        exp_ur = !busy && !m_pend && !(hs_tx && m_pause);
        exp_tv = exp_fc || (exp_ur && uv);
        chk(usr_ready == exp_ur, "R8", "usr_ready", usr_ready, exp_ur);
        chk(tx_valid == exp_tv, "R9", "tx_valid", tx_valid, exp_tv);
        if (exp_tv)
            chk(tx_data == (exp_fc ? m_fc : ud), "R9", "tx_data", tx_data, exp_fc ? m_fc : ud);
        ctrl = hs_tx && rv && is_ctl(rd);
        if (ctrl) m_pause = (rd == 8'h13);
        push = rv && !ctrl && (mq.size() < DEPTH);
        if (rv && !ctrl && mq.size() == DEPTH) m_ovf = 1;
        pop = pr && (mq.size() > 0);
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(rd);
        free = DEPTH - mq.size();
        if (push && hs_rx && !m_xs && free < 16) begin
            m_xs = 1; m_pend = 1; m_fc = 8'h13;
        end else if (m_xs && free >= 64) begin
            m_xs = 0; m_pend = 1; m_fc = 8'h11;
        end else if (exp_fc) begin
            m_pend = 0;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        hs_rx = 1; hs_tx = 1;
        do_reset();

        // R4 R9: fill with idle transmitter and a competing user character
        for (int i = 0; i < 245; i++) step(1, 8'h20 + 8'(i % 64), 0, 0, 1, 8'h55);
        chk(xoff_sent == 1'b1, "R4", "xoff_sent after fill", xoff_sent, 1);

        // R3: fill past capacity
        for (int i = 0; i < 14; i++) step(1, 8'h41, 0, 0, 0, 0);
        chk(overflow == 1'b1, "R3", "overflow after overrun", overflow, 1);

        // R6 R1 R2: drain completely, with extra pops while empty
        for (int i = 0; i < 262; i++) step(0, 0, 1, i % 3 == 0, 0, 0);
        chk(pop_empty == 1'b1, "R2", "empty after drain", pop_empty, 1);
        chk(xoff_sent == 1'b0, "R6", "xoff cleared after drain", xoff_sent, 0);

        // R5: XOFF raised while the transmitter is busy waits as a request
        do_reset();
        for (int i = 0; i < 241; i++) step(1, 8'h30, 0, 1, 1, 8'h66);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 8'h66);
        chk(fc_pending == 1'b1, "R5", "pending while busy", fc_pending, 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 8'h66);

        // R7: remote pause honoured, then plain storage when not honoured
        step(1, 8'h13, 0, 0, 1, 8'h77);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 8'h77);
        chk(paused == 1'b1, "R7", "paused after remote stop", paused, 1);
        step(1, 8'h11, 0, 0, 1, 8'h77);
        step(0, 0, 0, 0, 1, 8'h78);
        hs_tx = 0;
        step(1, 8'h13, 0, 0, 1, 8'h79);
        step(0, 0, 0, 0, 0, 0);
        chk(paused == 1'b0, "R7", "paused untouched when not honoured", paused, 0);

        // Random traffic alternating fill-heavy and drain-heavy phases
        for (int ph = 0; ph < 10; ph++) begin
            bit fill = (ph % 2 == 0);
            hs_rx = ($urandom % 4) != 0;
            hs_tx = $urandom % 2;
            for (int c = 0; c < 700; c++) begin
                byte unsigned d;
                d = ($urandom % 10 == 0) ? (($urandom % 2) ? 8'h13 : 8'h11) : 8'($urandom);
                step(($urandom % 100) < (fill ? 75 : 15), d,
                     ($urandom % 100) < (fill ? 10 : 80),
                     ($urandom % 100) < 30, $urandom % 2, 8'($urandom));
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule